// File: doc/BRIEF.md
# Drink Vending Credit Controller

This block is the control state machine of a single-product drink vending unit. The drink costs 150 units, and the unit takes coins worth 50 and 100. A coin front end, outside this block, reports each accepted coin as a one-cycle strobe on the line for its denomination. The controller keeps a running credit of 0, 50 or 100 within one sale.

Once the credit reaches the price, the controller raises a dispense pulse for one cycle. If the credit reaches 200, it also raises a pulse that returns one 50-unit coin. The controller then goes back to zero credit.

The outputs are of the Mealy kind: they depend on the current credit and the coin seen in the same cycle. The current credit is brought out as a 2-bit status code. The asynchronous active-low reset is released to the state register through a short synchronizer.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_n` is low, `credit_state` is 0 and `dispense` and `change_50` are low. This holds immediately, without waiting for a clock edge.
- R2: `credit_state` uses these codes: 0 means no credit, 2 means 50 units held and 1 means 100 units held. Code 3 is never presented.
- R3: With no credit, a 50 coin moves the credit to 50 and a 100 coin moves it to 100. Neither coin produces a dispense or a change pulse.
- R4: With 50 units held, a 50 coin moves the credit to 100 with no pulse. A 100 coin instead raises `dispense` without `change_50`, and the credit goes back to 0.
- R5: With 100 units held, a 50 coin raises `dispense` without `change_50`, and the credit goes back to 0.
- R6: With 100 units held, a 100 coin raises both `dispense` and `change_50`, and the credit goes back to 0.
- R7: In a cycle with no coin strobe, the credit holds and both pulses stay low.
- R8: When both strobes are high in the same cycle, the controller treats them as a single 100 coin and ignores the 50 strobe.
- R9: `dispense` and `change_50` are high only in the cycle in which the completing strobe is sampled, so each pulse lasts one cycle. `change_50` is never high without `dispense`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| coin_50 | input | 1 | One-cycle strobe: a 50-unit coin was accepted |
| coin_100 | input | 1 | One-cycle strobe: a 100-unit coin was accepted |
| dispense | output | 1 | One-cycle pulse: release one drink |
| change_50 | output | 1 | One-cycle pulse: return one 50-unit coin |
| credit_state | output | 2 | Current credit code (0, 2 or 1) |

## Verification
The dispense and change pulses are combinational in the present credit and the coin, so they are due in the same cycle as the strobe. The bench drives a strobe just after a falling edge and samples the pulses a few nanoseconds later, before the rising edge. The new credit code is due one rising edge later, so the bench samples it just after that edge and, at the same point, confirms that both pulses have fallen once the strobe is removed. After reset is released, the bench waits several cycles, longer than the reset synchronizer needs, before it applies any coin.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_EMPTY  = 2'd0,
    ST_HUNDRED = 2'd1,
    ST_FIFTY  = 2'd2
  } credit_e;

  typedef enum logic [1:0] {
    COIN_NONE    = 2'd0,
    COIN_FIFTY   = 2'd1,
    COIN_HUNDRED = 2'd2
  } coin_e;
endpackage

// File: rtl/vend_coin_sel.sv
module vend_coin_sel
  import vend_pkg::*;
(
  input  logic  coin_50,
  input  logic  coin_100,
  output coin_e coin
);
  // The larger coin wins when both strobes arrive together (R8).
  always_comb begin
    if (coin_100)     coin = COIN_HUNDRED;
    else if (coin_50) coin = COIN_FIFTY;
    else              coin = COIN_NONE;
  end
endmodule

// File: rtl/vend_next.sv
module vend_next
  import vend_pkg::*;
(
  input  credit_e state_q,
  input  coin_e   coin,
  output credit_e state_d,
  output logic    dispense,
  output logic    change_50
);
  always_comb begin
    state_d   = state_q;
    dispense  = 1'b0;
    change_50 = 1'b0;
    case (state_q)
      ST_EMPTY: begin
        if (coin == COIN_FIFTY)        state_d = ST_FIFTY;
        else if (coin == COIN_HUNDRED) state_d = ST_HUNDRED;
      end
      ST_FIFTY: begin
        if (coin == COIN_FIFTY) state_d = ST_HUNDRED;
        else if (coin == COIN_HUNDRED) begin
          state_d  = ST_EMPTY;
          dispense = 1'b1;
        end
      end
      ST_HUNDRED: begin
        if (coin != COIN_NONE) begin
          state_d   = ST_EMPTY;
          dispense  = 1'b1;
          change_50 = (coin == COIN_HUNDRED);
        end
      end
      default: state_d = ST_EMPTY;
    endcase
  end
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
  import vend_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  credit_e state_d,
  output credit_e state_q
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   state_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  assign state_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    state_q <= ST_EMPTY;
    else if (state_en) state_q <= state_d;
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                coin_50,
  input  logic                coin_100,
  output logic                dispense,
  output logic                change_50,
  output logic [STATE_W-1:0]  credit_state
);
  coin_e   coin;
  credit_e state_q;
  credit_e state_d;

  vend_coin_sel u_sel (
    .coin_50 (coin_50),
    .coin_100(coin_100),
    .coin    (coin)
  );

  vend_next u_next (
    .state_q  (state_q),
    .coin     (coin),
    .state_d  (state_d),
    .dispense (dispense),
    .change_50(change_50)
  );

  vend_state_reg #(.SYNC_STAGES(SYNC_STAGES)) u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .state_d(state_d),
    .state_q(state_q)
  );

  assign credit_state = state_q;

  p_change_with_dispense_r9: assert property (@(posedge clk) disable iff (!rst_n)
    change_50 |-> dispense);
  p_empty_after_sale_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dispense |=> (credit_state == ST_EMPTY));
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!coin_50 && !coin_100) |=> $stable(credit_state));
  p_no_sale_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_state == ST_EMPTY) |-> !dispense);
  p_change_from_hundred_r6: assert property (@(posedge clk) disable iff (!rst_n)
    change_50 |-> (credit_state == ST_HUNDRED && coin_100));
  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    credit_state != 2'd3);
endmodule

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       coin_50, coin_100;
  logic       dispense, change_50;
  logic [1:0] credit_state;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vend_ctrl dut (
    .clk(clk), .rst_n(rst_n), .coin_50(coin_50), .coin_100(coin_100),
    .dispense(dispense), .change_50(change_50), .credit_state(credit_state)
  );

  // {coin_50, coin_100, exp_dispense, exp_change, exp_state_after[1:0]}
  localparam int NV = 14;
  localparam logic [5:0] VEC [NV] = '{
    6'b10_00_10, 6'b10_00_01, 6'b10_10_00, 6'b01_00_01, 6'b01_11_00,
    6'b00_00_00, 6'b10_00_10, 6'b00_00_10, 6'b01_10_00, 6'b11_00_01,
    6'b00_00_01, 6'b11_11_00, 6'b10_00_10, 6'b11_10_00
  };

  function automatic string req_of(logic [1:0] st, logic c5, logic c10);
    if (!c5 && !c10) return "R7";
    if (c5 && c10)   return "R8";
    if (st == 2'd0)  return "R3";
    if (st == 2'd2)  return "R4";
    if (c10)         return "R6";
    return "R5";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic apply(logic c5, logic c10, logic ed, logic ec, logic [1:0] es);
    string req;
    req = req_of(credit_state, c5, c10);
    @(negedge clk);
    coin_50 = c5; coin_100 = c10;
    #2;
    check(req, "dispense", dispense, ed);
    check(req, "change_50", change_50, ec);
    @(posedge clk);
    #1;
    coin_50 = 1'b0; coin_100 = 1'b0;
    #1;
    check(req, "credit_state (R2 code)", credit_state, es);
    check("R9", "dispense after strobe", dispense, 0);
    check("R9", "change_50 after strobe", change_50, 0);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; coin_50 = 1'b0; coin_100 = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "state in reset", credit_state, 0);
    check("R1", "dispense in reset", dispense, 0);
    check("R1", "change_50 in reset", change_50, 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    for (int i = 0; i < NV; i++)
      apply(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1:0]);

    // Directed: asynchronous reset while credit is held (R1).
    apply(1'b1, 1'b0, 1'b0, 1'b0, 2'd2);
    #2 rst_n = 1'b0;
    #1;
    check("R1", "state right after async reset", credit_state, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // Directed: long idle keeps 100 credit (R7), then exact sale (R5).
    apply(1'b0, 1'b1, 1'b0, 1'b0, 2'd1);
    repeat (5) apply(1'b0, 1'b0, 1'b0, 1'b0, 2'd1);
    apply(1'b1, 1'b0, 1'b1, 1'b0, 2'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule